// File: doc/BRIEF.md
# Transactional Commit Write Buffer

This block sits beside a processor core and gathers the stores it performs while a speculative transaction runs. The stores never touch the cache. Each distinct line goes into a small list of line tags, and its data goes into a separate data store that an FPGA can map onto block RAM. A later store to a line already in the list overwrites that entry in place, so every line appears only once.

When the core signals the end of a transaction, the block asks an external arbiter for system-wide commit permission. The request stays up until the grant arrives. The block then sends the whole write set as one framed packet, one beat per held line, in the order the lines were first written. New stores are stalled while the request is pending and while the packet drains. A one-cycle done pulse marks the end of the commit. If the transaction is violated, a discard input empties the buffer in a single cycle. A store that would need a new entry when every entry is in use is dropped, and the block raises a sticky overflow flag.

Top module: `txn_commit_buffer`

## Requirements
- R1: After reset, st_ready is 1 and cm_req, pk_valid, commit_done and st_overflow are all 0.
- R2: A store accepted with a tag that is not held takes a new entry. A store whose tag is already held overwrites that entry's data, so the packet carries one beat for that tag, with the data written last.
- R3: A store with a tag that is not held, made while all DEPTH entries are in use, is dropped and st_overflow is 1 from the next cycle. The flag stays set until a discard or a completed commit. Stores that merge into held tags are still accepted while the buffer is full.
- R4: tx_end in the idle state with at least one entry held raises cm_req from the next cycle. cm_req stays 1 until the cycle in which cm_grant is seen, and is 0 after it.
- R5: pk_valid never rises unless cm_req and cm_grant were both 1 in the previous cycle.
- R6: The packet has one beat per held entry, in first-write order. pk_first is 1 only on the first beat and pk_last is 1 only on the last beat (both are 1 for a single-entry packet). A beat holds pk_tag, pk_data, pk_first and pk_last stable while pk_ready is 0.
- R7: In the cycle after the last beat is accepted (pk_valid, pk_ready and pk_last all 1), commit_done is 1 for exactly one cycle, the buffer is empty and st_ready is 1.
- R8: st_ready is 0 from the cycle after tx_end until the commit ends. Stores presented during that time are ignored and do not appear in any later packet.
- R9: discard empties the buffer in one cycle from any state. From the next cycle cm_req, pk_valid and st_overflow are 0 and st_ready is 1.
- R10: tx_end in the idle state with no entry held raises no request; commit_done is 1 for one cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A store is presented |
| st_tag | input | TAG_W | Line tag of the store |
| st_data | input | DATA_W | Line data of the store |
| st_ready | output | 1 | Stores are accepted (idle state) |
| st_overflow | output | 1 | Sticky flag: a store was dropped because the buffer was full |
| tx_end | input | 1 | End-of-transaction strobe |
| discard | input | 1 | Violation: drop all buffered entries |
| cm_req | output | 1 | Commit permission request to the arbiter |
| cm_grant | input | 1 | Commit permission from the arbiter |
| pk_valid | output | 1 | Packet beat is valid |
| pk_ready | input | 1 | Packet beat is accepted by the receiver |
| pk_tag | output | TAG_W | Line tag of the beat |
| pk_data | output | DATA_W | Line data of the beat |
| pk_first | output | 1 | First beat of the packet |
| pk_last | output | 1 | Last beat of the packet |
| commit_done | output | 1 | One-cycle pulse after the last beat is accepted |

## Verification
The assertions are checked on every cycle and cover the handshake rules: the request is held until grant, no beat appears without a grant, a stalled beat stays stable, commit_done is a single pulse after the last beat, stores are stalled while a commit is in flight, discard clears state, and the overflow flag is sticky. Only the bench scenarios can show that the contents are right. They check that merged stores give one beat with the newest data, that beats come out in first-write order with correct framing, that a store dropped on overflow is really missing from the packet, and that stores presented during a stall never appear later. They also check that an empty transaction completes without a request.

// File: rtl/txn_commit_pkg.sv
package txn_commit_pkg;
  typedef enum logic [1:0] {
    CB_IDLE = 2'd0,
    CB_REQ  = 2'd1,
    CB_SEND = 2'd2
  } cb_state_e;
endpackage

// File: rtl/cb_tag_list.sv
module cb_tag_list #(
  parameter int TAG_W = 8,
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             alloc,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [CNT_W-1:0] count,
  output logic             full,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign match[gi] = (CNT_W'(gi) < cnt_q) && (tag_q[gi] == lk_tag);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit    = |match;
  assign count  = cnt_q;
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign rd_tag = tag_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (alloc && !full) begin
      tag_q[cnt_q[IDX_W-1:0]] <= lk_tag;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cb_data_ram.sv
module cb_data_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cb_commit_fsm.sv
module cb_commit_fsm
  import txn_commit_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_end,
  input  logic             discard,
  input  logic             cm_grant,
  input  logic             pk_ready,
  input  logic [CNT_W-1:0] count,
  output logic             idle,
  output logic             cm_req,
  output logic             pk_valid,
  output logic             pk_first,
  output logic             pk_last,
  output logic             commit_done,
  output logic             clear,
  output logic [IDX_W-1:0] beat_idx,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr
);
  cb_state_e        state_q;
  logic [IDX_W-1:0] beat_q;
  logic             valid_q;
  logic             done_q;
  logic             last_beat;
  logic             fire_last;

  assign last_beat = (CNT_W'(beat_q) == count - CNT_W'(1));

  always_comb begin
    rd_en     = 1'b0;
    rd_addr   = beat_q;
    fire_last = 1'b0;
    if (!discard) begin
      case (state_q)
        CB_REQ: if (cm_grant) begin
          rd_en   = 1'b1;
          rd_addr = '0;
        end
        CB_SEND: if (pk_ready) begin
          if (last_beat) fire_last = 1'b1;
          else begin
            rd_en   = 1'b1;
            rd_addr = beat_q + IDX_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CB_IDLE;
      beat_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (discard) begin
        state_q <= CB_IDLE;
        valid_q <= 1'b0;
      end else begin
        case (state_q)
          CB_IDLE: if (tx_end) begin
            if (count == '0) done_q <= 1'b1;
            else state_q <= CB_REQ;
          end
          CB_REQ: if (cm_grant) begin
            state_q <= CB_SEND;
            valid_q <= 1'b1;
            beat_q  <= '0;
          end
          CB_SEND: if (pk_ready) begin
            if (last_beat) begin
              state_q <= CB_IDLE;
              valid_q <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              beat_q <= beat_q + IDX_W'(1);
            end
          end
          default: state_q <= CB_IDLE;
        endcase
      end
    end
  end

  assign idle        = (state_q == CB_IDLE);
  assign cm_req      = (state_q == CB_REQ);
  assign pk_valid    = valid_q;
  assign pk_first    = valid_q && (beat_q == '0);
  assign pk_last     = valid_q && last_beat;
  assign commit_done = done_q;
  assign clear       = discard || fire_last;
  assign beat_idx    = beat_q;
endmodule

// File: rtl/txn_commit_buffer.sv
module txn_commit_buffer #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  output logic              st_overflow,
  input  logic              tx_end,
  input  logic              discard,
  output logic              cm_req,
  input  logic              cm_grant,
  output logic              pk_valid,
  input  logic              pk_ready,
  output logic [TAG_W-1:0]  pk_tag,
  output logic [DATA_W-1:0] pk_data,
  output logic              pk_first,
  output logic              pk_last,
  output logic              commit_done
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             idle, clear, hit, full, st_acc, alloc, wr_en, rd_en;
  logic [IDX_W-1:0] hit_idx, beat_idx, rd_addr, wr_addr;
  logic [CNT_W-1:0] count;
  logic             ovf_q;

  assign st_acc  = st_valid && idle && !discard;
  assign alloc   = st_acc && !hit && !full;
  assign wr_en   = st_acc && (hit || !full);
  assign wr_addr = hit ? hit_idx : count[IDX_W-1:0];

  cb_tag_list #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst(rst), .clear(clear), .alloc(alloc), .lk_tag(st_tag),
    .hit(hit), .hit_idx(hit_idx), .count(count), .full(full),
    .rd_idx(beat_idx), .rd_tag(pk_tag)
  );

  cb_data_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(st_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(pk_data)
  );

  cb_commit_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst(rst), .tx_end(tx_end), .discard(discard),
    .cm_grant(cm_grant), .pk_ready(pk_ready), .count(count),
    .idle(idle), .cm_req(cm_req), .pk_valid(pk_valid), .pk_first(pk_first),
    .pk_last(pk_last), .commit_done(commit_done), .clear(clear),
    .beat_idx(beat_idx), .rd_en(rd_en), .rd_addr(rd_addr)
  );

  always_ff @(posedge clk) begin
    if (rst || clear) ovf_q <= 1'b0;
    else if (st_acc && !hit && full) ovf_q <= 1'b1;
  end

  assign st_ready    = idle;
  assign st_overflow = ovf_q;
endmodule

// File: rtl/txn_commit_buffer_chk.sv
module txn_commit_buffer_chk #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              discard,
  input logic              st_ready,
  input logic              st_overflow,
  input logic              cm_req,
  input logic              cm_grant,
  input logic              pk_valid,
  input logic              pk_ready,
  input logic [TAG_W-1:0]  pk_tag,
  input logic [DATA_W-1:0] pk_data,
  input logic              pk_first,
  input logic              pk_last,
  input logic              commit_done
);
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    (cm_req && !cm_grant && !discard) |=> cm_req);

  a_r5_grant_first: assert property (@(posedge clk) disable iff (rst)
    $rose(pk_valid) |-> $past(cm_req && cm_grant));

  a_r6_beat_stable: assert property (@(posedge clk) disable iff (rst)
    (pk_valid && !pk_ready && !discard) |=>
      (pk_valid && $stable(pk_tag) && $stable(pk_data) &&
       $stable(pk_first) && $stable(pk_last)));

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (pk_valid && pk_ready && pk_last && !discard) |=> (commit_done && st_ready));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    commit_done |=> !commit_done);

  a_r8_stall_stores: assert property (@(posedge clk) disable iff (rst)
    (cm_req || pk_valid) |-> !st_ready);

  a_r9_discard_clears: assert property (@(posedge clk) disable iff (rst)
    discard |=> (!cm_req && !pk_valid && !st_overflow && st_ready));

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (st_overflow && !discard && !(pk_valid && pk_ready && pk_last)) |=> st_overflow);
endmodule

bind txn_commit_buffer txn_commit_buffer_chk #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .discard(discard), .st_ready(st_ready),
  .st_overflow(st_overflow), .cm_req(cm_req), .cm_grant(cm_grant),
  .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_tag(pk_tag), .pk_data(pk_data),
  .pk_first(pk_first), .pk_last(pk_last), .commit_done(commit_done)
);

// File: tb/sim_txn_commit_buffer.sv
module sim_txn_commit_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [7:0]  st_tag = '0;
  logic [15:0] st_data = '0;
  logic        st_ready, st_overflow;
  logic        tx_end = 1'b0, discard = 1'b0;
  logic        cm_req;
  logic        cm_grant = 1'b0;
  logic        pk_valid;
  logic        pk_ready = 1'b0;
  logic [7:0]  pk_tag;
  logic [15:0] pk_data;
  logic        pk_first, pk_last, commit_done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // store vectors {tag, data}; tag 0x10 and 0x20 are written twice (merge)
  localparam logic [23:0] STORES [5] = '{
    {8'h10, 16'h1111}, {8'h20, 16'h2222}, {8'h10, 16'h3333},
    {8'h30, 16'h4444}, {8'h20, 16'h5555}
  };
  // expected packet beats in first-write order with the newest data
  localparam logic [23:0] BEATS [3] = '{
    {8'h10, 16'h3333}, {8'h20, 16'h5555}, {8'h30, 16'h4444}
  };

  always #5 clk = ~clk;

  txn_commit_buffer u0 (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_tag(st_tag),
    .st_data(st_data), .st_ready(st_ready), .st_overflow(st_overflow),
    .tx_end(tx_end), .discard(discard), .cm_req(cm_req), .cm_grant(cm_grant),
    .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_tag(pk_tag),
    .pk_data(pk_data), .pk_first(pk_first), .pk_last(pk_last),
    .commit_done(commit_done)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic store(input logic [7:0] t, input logic [15:0] d);
    st_valid = 1'b1; st_tag = t; st_data = d;
    step();
    st_valid = 1'b0;
  endtask

  task automatic begin_commit();
    tx_end = 1'b1; step(); tx_end = 1'b0;
    chk("R4 req after tx_end", 32'(cm_req), 32'd1);
    cm_grant = 1'b1; step(); cm_grant = 0;
    chk("R4 req drops after grant", 32'(cm_req), 32'd0);
  endtask

  task automatic take_beat(input string req, input logic [7:0] t, input logic [15:0] d,
                           input bit f, input bit l);
    chk({req, " valid"}, 32'(pk_valid), 32'd1);
    chk({req, " tag"}, 32'(pk_tag), 32'(t));
    chk({req, " data"}, 32'(pk_data), 32'(d));
    chk({req, " first"}, 32'(pk_first), 32'(f));
    chk({req, " last"}, 32'(pk_last), 32'(l));
    pk_ready = 1'b1; step(); pk_ready = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    chk("R1 st_ready", 32'(st_ready), 32'd1);
    chk("R1 cm_req", 32'(cm_req), 32'd0);
    chk("R1 pk_valid", 32'(pk_valid), 32'd0);
    chk("R1 commit_done", 32'(commit_done), 32'd0);
    chk("R1 st_overflow", 32'(st_overflow), 32'd0);

    // table walk: stores with merges
    for (int i = 0; i < 5; i++) store(STORES[i][23:16], STORES[i][15:0]);

    tx_end = 1'b1; step(); tx_end = 1'b0;
    chk("R4 req raised", 32'(cm_req), 32'd1);
    chk("R8 stalled", 32'(st_ready), 32'd0);
    st_valid = 1'b1; st_tag = 8'h77; st_data = 16'hdead;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5 no beat before grant", 32'(pk_valid), 32'd0);
      chk("R4 req held", 32'(cm_req), 32'd1);
    end
    st_valid = 1'b0;
    cm_grant = 1'b1; step(); cm_grant = 1'b0;
    chk("R4 req drops after grant", 32'(cm_req), 32'd0);
    chk("R5 beat after grant", 32'(pk_valid), 32'd1);
    step();
    chk("R6 hold tag", 32'(pk_tag), 32'(BEATS[0][23:16]));
    chk("R6 hold data", 32'(pk_data), 32'(BEATS[0][15:0]));
    for (int b = 0; b < 3; b++)
      take_beat("R2 R6 beat", BEATS[b][23:16], BEATS[b][15:0], b == 0, b == 2);
    chk("R7 done pulse", 32'(commit_done), 32'd1);
    chk("R7 ready again", 32'(st_ready), 32'd1);
    chk("R7 packet ended", 32'(pk_valid), 32'd0);
    step();
    chk("R7 done one cycle", 32'(commit_done), 32'd0);

    // stalled store 0x77 must not appear; single-entry packet
    store(8'h40, 16'haaaa);
    begin_commit();
    take_beat("R8 R6 single beat", 8'h40, 16'haaaa, 1'b1, 1'b1);
    chk("R7 done single", 32'(commit_done), 32'd1);

    // overflow
    for (int i = 1; i <= 4; i++) store(8'(i), 16'(16'h0100 + i - 1));
    chk("R3 no overflow when exactly full", 32'(st_overflow), 32'd0);
    store(8'h05, 16'h0555);
    chk("R3 overflow set", 32'(st_overflow), 32'd1);
    store(8'h02, 16'h0222);
    chk("R3 overflow sticky", 32'(st_overflow), 32'd1);
    begin_commit();
    take_beat("R3 beat", 8'h01, 16'h0100, 1'b1, 1'b0);
    take_beat("R3 merged while full", 8'h02, 16'h0222, 1'b0, 1'b0);
    take_beat("R3 beat", 8'h03, 16'h0102, 1'b0, 1'b0);
    take_beat("R3 dropped tag absent", 8'h04, 16'h0103, 1'b0, 1'b1);
    chk("R7 done after overflow commit", 32'(commit_done), 32'd1);
    chk("R3 overflow cleared", 32'(st_overflow), 32'd0);

    // discard while requesting
    store(8'h08, 16'h0808);
    store(8'h09, 16'h0909);
    tx_end = 1'b1; step(); tx_end = 1'b0;
    chk("R9 pre req", 32'(cm_req), 32'd1);
    discard = 1'b1; step(); discard = 1'b0;
    chk("R9 req cleared", 32'(cm_req), 32'd0);
    chk("R9 ready", 32'(st_ready), 32'd1);
    tx_end = 1'b1; step(); tx_end = 1'b0;
    chk("R10 empty done", 32'(commit_done), 32'd1);
    chk("R10 no req", 32'(cm_req), 32'd0);

    // discard while sending
    store(8'h06, 16'h0606);
    begin_commit();
    chk("R9 sending", 32'(pk_valid), 32'd1);
    discard = 1'b1; step(); discard = 1'b0;
    chk("R9 packet dropped", 32'(pk_valid), 32'd0);
    tx_end = 1'b1; step(); tx_end = 1'b0;
    chk("R9 R10 emptied", 32'(commit_done), 32'd1);
    chk("R10 no req after discard", 32'(cm_req), 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule